// File: doc/BRIEF.md
# Work-Group Thread-Slot Dispatcher

This block takes work-group launch requests and places each group's hardware threads onto the thread contexts of a row of compute clusters. A cluster holds eight execution units of seven contexts each, so it has 56 thread slots. A cluster also limits how many groups may be resident on it at once, and it has a 64 KiB budget of local scratch memory. A request carries a group id, a work-group size, a sub-group width code, a scratch byte count and a flag. The flag is set when the group synchronises with barriers or shares scratch memory, and in that case the whole group must land on a single cluster. A group without the flag may spread its threads over free slots on any clusters.

Placement is first-fit. Clusters are scanned in ascending order, and inside the chosen region the lowest free slot numbers are taken first, which fills one execution unit before the next. An accepted request produces, one cycle later, a one-cycle grant pulse with the group id, a cluster number and the slot mask. A request that can never be placed is consumed and answered with an error pulse and a cause code. A request that could fit later keeps `req_ready` low until it fits. A completion pulse naming a resident group returns that group's slots, its scratch bytes and its residency count in one clock edge.

Top module: `wg_dispatch`

## Requirements
- R1: A group's thread count is the work-group size divided by the sub-group width, rounded up. The width code is 0 for 8 lanes, 1 for 16 and 2 for 32. A granted slot mask has exactly that many bits set.
- R2: Slot number c*56 + u*7 + t names context t of execution unit u on cluster c. Grants take the lowest-numbered free slots in the allowed region first.
- R3: A group with the sync flag set gets all of its slots on one cluster. That cluster is the lowest-numbered one with enough free slots, fewer than 16 resident groups and enough scratch headroom, and `grant_cluster` reports it.
- R4: The scratch bytes of the synchronising groups on a cluster never total more than 65536. A sync request that no cluster has room for waits.
- R5: No cluster holds more than 16 resident groups. A spreading group counts once on every cluster where it holds a slot, and a cluster at the cap is given no slots.
- R6: A group without the sync flag may take slots on several clusters, and its scratch byte count is ignored. `grant_cluster` is then the lowest cluster holding one of its slots.
- R7: A request is never placeable, and is consumed with an error pulse, in these cases: width code 3 gives cause 1; a thread count of 0, a sync group of more than 56 threads or a spreading group of more than all slots gives cause 2; a sync group asking for more than 65536 bytes gives cause 3. No grant is made and no resource is taken.
- R8: A request that fits no cluster now, or whose group id is still resident, is held with `req_ready` low and does not error.
- R9: A completion pulse for a resident group frees its slots, its scratch bytes and its residency counts at that clock edge, so a request waiting on them is accepted at the next edge.
- R10: After reset no slot is busy, both pulse outputs are low, and a placeable request sees `req_ready` high.
- R11: The grant and error outputs are pulses that last one cycle and appear in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Request is taken at this edge (placed or rejected) |
| req_gid | input | GID_W (5) | Group id |
| req_wg_size | input | WGS_W (12) | Work-items in the group |
| req_sg_sel | input | 2 | Sub-group width code: 0=8, 1=16, 2=32 |
| req_slm_bytes | input | REQ_SLM_W (18) | Scratch bytes requested |
| req_sync | input | 1 | Group uses barriers or shared scratch memory |
| done_valid | input | 1 | Completion pulse |
| done_gid | input | GID_W (5) | Id of the completing group |
| grant_valid | output | 1 | Placement pulse |
| grant_gid | output | GID_W (5) | Id of the placed group |
| grant_cluster | output | CL_W (1) | Cluster of the placement |
| grant_slots | output | TOTAL_SLOTS (112) | Thread slot mask |
| err_valid | output | 1 | Launch error pulse |
| err_gid | output | GID_W (5) | Id of the rejected group |
| err_cause | output | 2 | 1 sub-group code, 2 thread count, 3 scratch size |

## Verification
A table drives a run of launches with no completions in between. It mixes sync and spreading groups across all three width codes and includes a rounded-up thread count. Because nothing is freed, each grant must be a contiguous run of slots whose start proves that earlier grants and rejections took exactly what they should. Sync groups that spill to cluster 1 while cluster 0 still has a few slots free separate the single-cluster rule from plain lowest-slot filling. A spreading group that straddles both clusters separates the two policies in the other direction. Directed cases then cover a scratch-headroom stall released by a completion, a stall on a resident id, the group cap pushing single-thread groups onto cluster 1, and a freed slot being reused.

// File: rtl/wgd_pkg.sv
package wgd_pkg;

    typedef enum logic [1:0] {
        SG_W8   = 2'd0,
        SG_W16  = 2'd1,
        SG_W32  = 2'd2,
        SG_NONE = 2'd3
    } sg_code_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_SGCODE  = 2'd1,
        CAUSE_THREADS = 2'd2,
        CAUSE_SCRATCH = 2'd3
    } err_cause_e;

endpackage

// File: rtl/wgd_req_decode.sv
module wgd_req_decode
    import wgd_pkg::*;
#(
    parameter int WGS_W         = 12,
    parameter int REQ_SLM_W     = 18,
    parameter int SLOTS_PER_CL  = 56,
    parameter int TOTAL_SLOTS   = 112,
    parameter int SCRATCH_BYTES = 65536
) (
    input  logic [WGS_W-1:0]     wg_size,
    input  logic [1:0]           sg_sel,
    input  logic [REQ_SLM_W-1:0] slm_bytes,
    input  logic                 sync,
    output logic [WGS_W-1:0]     threads,
    output logic                 never_fits,
    output err_cause_e           cause
);

    localparam logic [WGS_W-1:0]     CL_LIMIT  = WGS_W'(SLOTS_PER_CL);
    localparam logic [WGS_W-1:0]     ALL_LIMIT = WGS_W'(TOTAL_SLOTS);
    localparam logic [REQ_SLM_W-1:0] SCR_LIMIT = REQ_SLM_W'(SCRATCH_BYTES);

    logic [WGS_W:0] rounded;
    logic           bad_code;

    // Thread count: ceiling of size over sub-group width.
    always_comb begin
        rounded  = '0;
        threads  = '0;
        bad_code = 1'b0;
        unique case (sg_code_e'(sg_sel))
            SG_W8: begin
                rounded = {1'b0, wg_size} + (WGS_W+1)'(7);
                threads = WGS_W'(rounded >> 3);
            end
            SG_W16: begin
                rounded = {1'b0, wg_size} + (WGS_W+1)'(15);
                threads = WGS_W'(rounded >> 4);
            end
            SG_W32: begin
                rounded = {1'b0, wg_size} + (WGS_W+1)'(31);
                threads = WGS_W'(rounded >> 5);
            end
            default: bad_code = 1'b1;
        endcase
    end

    // Permanent rejection checks, in priority order.
    always_comb begin
        never_fits = 1'b1;
        cause      = CAUSE_NONE;
        if (bad_code) begin
            cause = CAUSE_SGCODE;
        end else if (threads == '0) begin
            cause = CAUSE_THREADS;
        end else if (sync && (threads > CL_LIMIT)) begin
            cause = CAUSE_THREADS;
        end else if (!sync && (threads > ALL_LIMIT)) begin
            cause = CAUSE_THREADS;
        end else if (sync && (slm_bytes > SCR_LIMIT)) begin
            cause = CAUSE_SCRATCH;
        end else begin
            never_fits = 1'b0;
        end
    end

endmodule

// File: rtl/wgd_cluster_pick.sv
module wgd_cluster_pick #(
    parameter int NUM_CLUSTERS  = 2,
    parameter int SLOTS_PER_CL  = 56,
    parameter int MAX_GROUPS    = 16,
    parameter int SCRATCH_BYTES = 65536,
    parameter int WGS_W         = 12,
    parameter int REQ_SLM_W     = 18,
    parameter int CNT_W         = 5,
    parameter int SLM_W         = 17,
    parameter int CL_W          = 1,
    localparam int TOTAL_SLOTS  = NUM_CLUSTERS * SLOTS_PER_CL
) (
    input  logic [TOTAL_SLOTS-1:0]              busy,
    input  logic [NUM_CLUSTERS-1:0][CNT_W-1:0]  grp_cnt,
    input  logic [NUM_CLUSTERS-1:0][SLM_W-1:0]  slm_used,
    input  logic [WGS_W-1:0]                    threads,
    input  logic [REQ_SLM_W-1:0]                slm_req,
    input  logic                                sync,
    output logic [TOTAL_SLOTS-1:0]              avail,
    output logic                                fit,
    output logic [CL_W-1:0]                     sel_cl
);

    localparam int SUM_W = REQ_SLM_W + 1;
    localparam logic [SUM_W-1:0] SCR_LIMIT = SUM_W'(SCRATCH_BYTES);
    localparam logic [CNT_W-1:0] CAP       = CNT_W'(MAX_GROUPS);
    localparam int ACC_W = WGS_W + $clog2(NUM_CLUSTERS + 1);

    logic [NUM_CLUSTERS-1:0][WGS_W-1:0] free_cnt;
    logic [NUM_CLUSTERS-1:0]            room_ok;
    logic [NUM_CLUSTERS-1:0]            sync_ok;

    for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cl
        logic [SUM_W-1:0] scr_sum;
        assign free_cnt[c] = WGS_W'($countones(~busy[c*SLOTS_PER_CL +: SLOTS_PER_CL]));
        assign room_ok[c]  = grp_cnt[c] < CAP;
        assign scr_sum     = SUM_W'(slm_used[c]) + SUM_W'(slm_req);
        assign sync_ok[c]  = room_ok[c] && (free_cnt[c] >= threads) && (scr_sum <= SCR_LIMIT);
    end

    logic             found;
    logic [ACC_W-1:0] spread_free;

    always_comb begin
        found       = 1'b0;
        sel_cl      = '0;
        spread_free = '0;
        avail       = '0;
        // First-fit in ascending cluster order for confined groups.
        for (int c = 0; c < NUM_CLUSTERS; c++) begin
            if (!found && sync_ok[c]) begin
                found  = 1'b1;
                sel_cl = CL_W'(c);
            end
            if (room_ok[c]) begin
                spread_free = spread_free + ACC_W'(free_cnt[c]);
            end
        end
        for (int c = 0; c < NUM_CLUSTERS; c++) begin
            if (sync ? (found && (sel_cl == CL_W'(c))) : room_ok[c]) begin
                avail[c*SLOTS_PER_CL +: SLOTS_PER_CL] = ~busy[c*SLOTS_PER_CL +: SLOTS_PER_CL];
            end
        end
        fit = sync ? found : (spread_free >= ACC_W'(threads));
    end

endmodule

// File: rtl/wgd_slot_alloc.sv
module wgd_slot_alloc #(
    parameter int N_SLOTS = 112,
    parameter int NEED_W  = 12
) (
    input  logic [N_SLOTS-1:0] avail,
    input  logic [NEED_W-1:0]  need,
    output logic [N_SLOTS-1:0] grant
);

    logic [NEED_W-1:0] taken;

    // Lowest-index-first pick of the first 'need' available slots.
    always_comb begin
        grant = '0;
        taken = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (avail[i] && (taken < need)) begin
                grant[i] = 1'b1;
                taken    = taken + NEED_W'(1);
            end
        end
    end

endmodule

// File: rtl/wg_dispatch.sv
module wg_dispatch
    import wgd_pkg::*;
#(
    parameter int NUM_CLUSTERS    = 2,
    parameter int EUS_PER_CLUSTER = 8,
    parameter int CTX_PER_EU      = 7,
    parameter int MAX_GROUPS      = 16,
    parameter int SCRATCH_BYTES   = 65536,
    parameter int NUM_GIDS        = 32,
    parameter int WGS_W           = 12,
    parameter int REQ_SLM_W       = 18,
    localparam int SLOTS_PER_CL   = EUS_PER_CLUSTER * CTX_PER_EU,
    localparam int TOTAL_SLOTS    = NUM_CLUSTERS * SLOTS_PER_CL,
    localparam int GID_W          = $clog2(NUM_GIDS),
    localparam int CL_W           = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [GID_W-1:0]       req_gid,
    input  logic [WGS_W-1:0]       req_wg_size,
    input  logic [1:0]             req_sg_sel,
    input  logic [REQ_SLM_W-1:0]   req_slm_bytes,
    input  logic                   req_sync,
    input  logic                   done_valid,
    input  logic [GID_W-1:0]       done_gid,
    output logic                   grant_valid,
    output logic [GID_W-1:0]       grant_gid,
    output logic [CL_W-1:0]        grant_cluster,
    output logic [TOTAL_SLOTS-1:0] grant_slots,
    output logic                   err_valid,
    output logic [GID_W-1:0]       err_gid,
    output logic [1:0]             err_cause
);

    localparam int CNT_W = $clog2(MAX_GROUPS + 1);
    localparam int SLM_W = $clog2(SCRATCH_BYTES + 1);

    typedef struct packed {
        logic [TOTAL_SLOTS-1:0]                 busy;
        logic [NUM_CLUSTERS-1:0][CNT_W-1:0]     cnt;
        logic [NUM_CLUSTERS-1:0][SLM_W-1:0]     slm;
        logic [NUM_GIDS-1:0]                    tv;
        logic [NUM_GIDS-1:0][TOTAL_SLOTS-1:0]   tmask;
        logic [NUM_GIDS-1:0][SLM_W-1:0]         tslm;
        logic [NUM_GIDS-1:0][CL_W-1:0]          tcl;
        logic                                   gv;
        logic [GID_W-1:0]                       ggid;
        logic [CL_W-1:0]                        gcl;
        logic [TOTAL_SLOTS-1:0]                 gmask;
        logic                                   gsync;
        logic                                   ev;
        logic [GID_W-1:0]                       egid;
        err_cause_e                             ecause;
    } state_t;

    state_t st_d, st_q;

    logic [WGS_W-1:0]       thr;
    logic                   is_err;
    err_cause_e             cause;
    logic [TOTAL_SLOTS-1:0] avail;
    logic                   fit;
    logic [CL_W-1:0]        sel_cl;
    logic [TOTAL_SLOTS-1:0] grant_m;

    wgd_req_decode #(
        .WGS_W(WGS_W), .REQ_SLM_W(REQ_SLM_W), .SLOTS_PER_CL(SLOTS_PER_CL),
        .TOTAL_SLOTS(TOTAL_SLOTS), .SCRATCH_BYTES(SCRATCH_BYTES)
    ) u_decode (
        .wg_size(req_wg_size), .sg_sel(req_sg_sel), .slm_bytes(req_slm_bytes),
        .sync(req_sync), .threads(thr), .never_fits(is_err), .cause(cause)
    );

    wgd_cluster_pick #(
        .NUM_CLUSTERS(NUM_CLUSTERS), .SLOTS_PER_CL(SLOTS_PER_CL), .MAX_GROUPS(MAX_GROUPS),
        .SCRATCH_BYTES(SCRATCH_BYTES), .WGS_W(WGS_W), .REQ_SLM_W(REQ_SLM_W),
        .CNT_W(CNT_W), .SLM_W(SLM_W), .CL_W(CL_W)
    ) u_pick (
        .busy(st_q.busy), .grp_cnt(st_q.cnt), .slm_used(st_q.slm), .threads(thr),
        .slm_req(req_slm_bytes), .sync(req_sync), .avail(avail), .fit(fit), .sel_cl(sel_cl)
    );

    wgd_slot_alloc #(.N_SLOTS(TOTAL_SLOTS), .NEED_W(WGS_W)) u_alloc (
        .avail(avail), .need(thr), .grant(grant_m)
    );

    logic                   gid_busy;
    logic                   accept;
    logic                   done_hit;
    logic [TOTAL_SLOTS-1:0] fmask;
    logic [CL_W-1:0]        span_cl;
    logic                   span_found;

    assign gid_busy  = st_q.tv[req_gid];
    assign req_ready = is_err || (fit && !gid_busy);
    assign accept    = req_valid && req_ready;
    assign done_hit  = done_valid && st_q.tv[done_gid];
    assign fmask     = st_q.tmask[done_gid];

    always_comb begin
        st_d       = st_q;
        st_d.gv    = 1'b0;
        st_d.ev    = 1'b0;
        span_cl    = '0;
        span_found = 1'b0;
        for (int c = 0; c < NUM_CLUSTERS; c++) begin
            if (!span_found && (|grant_m[c*SLOTS_PER_CL +: SLOTS_PER_CL])) begin
                span_found = 1'b1;
                span_cl    = CL_W'(c);
            end
        end
        // Release of a completed group.
        if (done_hit) begin
            st_d.busy = st_d.busy & ~fmask;
            for (int c = 0; c < NUM_CLUSTERS; c++) begin
                if (|fmask[c*SLOTS_PER_CL +: SLOTS_PER_CL]) begin
                    st_d.cnt[c] = st_d.cnt[c] - CNT_W'(1);
                end
            end
            st_d.slm[st_q.tcl[done_gid]] = st_d.slm[st_q.tcl[done_gid]] - st_q.tslm[done_gid];
            st_d.tv[done_gid] = 1'b0;
        end
        // Acceptance of a request, judged on the registered state.
        if (accept) begin
            if (is_err) begin
                st_d.ev     = 1'b1;
                st_d.egid   = req_gid;
                st_d.ecause = cause;
            end else begin
                st_d.gv    = 1'b1;
                st_d.ggid  = req_gid;
                st_d.gcl   = req_sync ? sel_cl : span_cl;
                st_d.gmask = grant_m;
                st_d.gsync = req_sync;
                st_d.busy  = st_d.busy | grant_m;
                for (int c = 0; c < NUM_CLUSTERS; c++) begin
                    if (|grant_m[c*SLOTS_PER_CL +: SLOTS_PER_CL]) begin
                        st_d.cnt[c] = st_d.cnt[c] + CNT_W'(1);
                    end
                end
                if (req_sync) begin
                    st_d.slm[sel_cl] = st_d.slm[sel_cl] + SLM_W'(req_slm_bytes);
                end
                st_d.tv[req_gid]    = 1'b1;
                st_d.tmask[req_gid] = grant_m;
                st_d.tslm[req_gid]  = req_sync ? SLM_W'(req_slm_bytes) : '0;
                st_d.tcl[req_gid]   = sel_cl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_valid   = st_q.gv;
    assign grant_gid     = st_q.ggid;
    assign grant_cluster = st_q.gcl;
    assign grant_slots   = st_q.gmask;
    assign err_valid     = st_q.ev;
    assign err_gid       = st_q.egid;
    assign err_cause     = st_q.ecause;

    logic [NUM_CLUSTERS-1:0] cl_touch;
    for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_chk
        assign cl_touch[c] = |grant_slots[c*SLOTS_PER_CL +: SLOTS_PER_CL];

        p_group_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[c] <= CNT_W'(MAX_GROUPS));

        p_scratch_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.slm[c] <= SLM_W'(SCRATCH_BYTES));
    end

    p_no_double_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_err) |-> ((grant_m & st_q.busy) == '0));

    p_thread_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_err) |=> ($countones(grant_slots) == int'($past(thr))));

    p_sync_one_cluster_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && st_q.gsync) |-> ($countones(cl_touch) == 1));

    p_grant_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && err_valid));

endmodule

// File: tb/wg_dispatch_tb.sv
module wg_dispatch_tb;

    localparam int TOT = 112;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           req_valid;
    logic           req_ready;
    logic [4:0]     req_gid;
    logic [11:0]    req_wg_size;
    logic [1:0]     req_sg_sel;
    logic [17:0]    req_slm_bytes;
    logic           req_sync;
    logic           done_valid;
    logic [4:0]     done_gid;
    logic           grant_valid;
    logic [4:0]     grant_gid;
    logic [0:0]     grant_cluster;
    logic [TOT-1:0] grant_slots;
    logic           err_valid;
    logic [4:0]     err_gid;
    logic [1:0]     err_cause;

    always #10 clk = ~clk;

    wg_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_gid(req_gid), .req_wg_size(req_wg_size), .req_sg_sel(req_sg_sel),
        .req_slm_bytes(req_slm_bytes), .req_sync(req_sync), .done_valid(done_valid),
        .done_gid(done_gid), .grant_valid(grant_valid), .grant_gid(grant_gid),
        .grant_cluster(grant_cluster), .grant_slots(grant_slots), .err_valid(err_valid),
        .err_gid(err_gid), .err_cause(err_cause)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [TOT-1:0] span(input int lo, input int n);
        logic [TOT-1:0] m = '0;
        for (int i = 0; i < n; i++) m[lo+i] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic [4:0]  gid;
        logic [11:0] wg;
        logic [1:0]  sg;
        logic [17:0] slm;
        logic        sync;
        logic        is_err;
        logic [1:0]  cause;
        logic        cl;
        logic [6:0]  lo;
        logic [6:0]  n;
    } vec_t;

    // Launch sequence from reset with no completions in between.
    localparam vec_t TBL [11] = '{
        '{5'd0, 12'd64,   2'd0, 18'd1000,   1'b1, 1'b0, 2'd0, 1'b0, 7'd0,  7'd8},  // R1 R3
        '{5'd1, 12'd33,   2'd1, 18'd0,      1'b0, 1'b0, 2'd0, 1'b0, 7'd8,  7'd3},  // R1 rounding
        '{5'd2, 12'd64,   2'd3, 18'd0,      1'b0, 1'b1, 2'd1, 1'b0, 7'd0,  7'd0},  // R7 code
        '{5'd2, 12'd1800, 2'd2, 18'd0,      1'b1, 1'b1, 2'd2, 1'b0, 7'd0,  7'd0},  // R7 57 thr
        '{5'd2, 12'd64,   2'd0, 18'd70000,  1'b1, 1'b1, 2'd3, 1'b0, 7'd0,  7'd0},  // R7 scratch
        '{5'd2, 12'd0,    2'd0, 18'd0,      1'b0, 1'b1, 2'd2, 1'b0, 7'd0,  7'd0},  // R7 zero
        '{5'd2, 12'd1344, 2'd2, 18'd60000,  1'b1, 1'b0, 2'd0, 1'b0, 7'd11, 7'd42}, // R2 R4
        '{5'd3, 12'd128,  2'd1, 18'd0,      1'b1, 1'b0, 2'd0, 1'b1, 7'd56, 7'd8},  // R3 spill
        '{5'd4, 12'd40,   2'd0, 18'd4536,   1'b1, 1'b0, 2'd0, 1'b1, 7'd64, 7'd5},  // R3
        '{5'd5, 12'd16,   2'd0, 18'd200000, 1'b0, 1'b0, 2'd0, 1'b0, 7'd53, 7'd2},  // R6 slm ignored
        '{5'd6, 12'd3600, 2'd2, 18'd0,      1'b0, 1'b1, 2'd2, 1'b0, 7'd0,  7'd0}   // R7 >112
    };

    task automatic drive(input logic [4:0] gid, input logic [11:0] wg, input logic [1:0] sg,
                         input logic [17:0] slm, input logic sync);
        req_gid = gid; req_wg_size = wg; req_sg_sel = sg; req_slm_bytes = slm;
        req_sync = sync; req_valid = 1'b1;
    endtask

    // Present one request, expect immediate acceptance, check the pulse a cycle later.
    task automatic issue(input logic [4:0] gid, input logic [11:0] wg, input logic [1:0] sg,
                         input logic [17:0] slm, input logic sync, input bit exp_err,
                         input logic [1:0] exp_cause, input logic exp_cl,
                         input logic [TOT-1:0] exp_mask, input string req);
        @(negedge clk);
        drive(gid, wg, sg, slm, sync);
        #1;
        chk(req_ready == 1'b1, req, "ready", 128'(req_ready), 128'(1));
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (exp_err) begin
            chk(err_valid == 1'b1 && grant_valid == 1'b0, req, "err pulse",
                128'({err_valid, grant_valid}), 128'(2'b10));
            chk(err_cause == exp_cause && err_gid == gid, req, "err cause/gid",
                128'({err_cause, err_gid}), 128'({exp_cause, gid}));
        end else begin
            chk(grant_valid == 1'b1 && err_valid == 1'b0, req, "grant pulse",
                128'({grant_valid, err_valid}), 128'(2'b10));
            chk(grant_gid == gid && grant_cluster == exp_cl, req, "gid/cluster",
                128'({grant_gid, grant_cluster}), 128'({gid, exp_cl}));
            chk(grant_slots == exp_mask, req, "slots", 128'(grant_slots), 128'(exp_mask));
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; req_valid = 1'b0; done_valid = 1'b0; done_gid = '0;
        req_gid = '0; req_wg_size = '0; req_sg_sel = '0; req_slm_bytes = '0; req_sync = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        apply_reset();
        // R10: clean state after reset.
        #1;
        chk(grant_valid == 1'b0 && err_valid == 1'b0, "R10", "pulses after reset",
            128'({grant_valid, err_valid}), 128'(0));

        for (int i = 0; i < 11; i++) begin
            issue(TBL[i].gid, TBL[i].wg, TBL[i].sg, TBL[i].slm, TBL[i].sync, TBL[i].is_err,
                  TBL[i].cause, TBL[i].cl, span(int'(TBL[i].lo), int'(TBL[i].n)), "R1/R2/R3/R7 table");
        end

        // R11: pulse lasts one cycle.
        @(negedge clk); #1;
        chk(grant_valid == 1'b0 && err_valid == 1'b0, "R11", "pulse width",
            128'({grant_valid, err_valid}), 128'(0));

        // R6: spreading group straddles clusters: slot 55 then 69..71.
        issue(5'd6, 12'd32, 2'd0, 18'd0, 1'b0, 1'b0, 2'd0, 1'b0,
              span(55, 1) | span(69, 3), "R6");

        // R4 R8: scratch headroom missing on cluster 1, cluster 0 full.
        @(negedge clk);
        drive(5'd7, 12'd8, 2'd0, 18'd62000, 1'b1);
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(req_ready == 1'b0, "R4", "waits for scratch", 128'(req_ready), 128'(0));
            @(negedge clk);
            chk(grant_valid == 1'b0 && err_valid == 1'b0, "R8", "no pulse while waiting",
                128'({grant_valid, err_valid}), 128'(0));
        end
        // R9: completion of group 4 releases 4536 bytes and slots 64..68.
        done_valid = 1'b1; done_gid = 5'd4;
        @(negedge clk);
        done_valid = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R9", "ready after completion", 128'(req_ready), 128'(1));
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(grant_valid == 1'b1 && grant_cluster == 1'b1 && grant_slots == span(64, 1), "R9",
            "reuse freed slot", 128'(grant_slots), 128'(span(64, 1)));

        // R8: resident id stalls even though slots are free.
        @(negedge clk);
        drive(5'd0, 12'd8, 2'd0, 18'd0, 1'b0);
        #1;
        chk(req_ready == 1'b0, "R8", "resident id waits", 128'(req_ready), 128'(0));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(grant_valid == 1'b0, "R8", "no grant for resident id", 128'(grant_valid), 128'(0));

        // R10: reset clears all residency.
        apply_reset();
        #1;
        chk(grant_valid == 1'b0 && err_valid == 1'b0, "R10", "pulses after second reset",
            128'({grant_valid, err_valid}), 128'(0));
        issue(5'd0, 12'd8, 2'd0, 18'd0, 1'b0, 1'b0, 2'd0, 1'b0, span(0, 1), "R10");

        // R5: fill cluster 0 to 16 groups, then the cap pushes work to cluster 1.
        for (int g = 1; g < 16; g++) begin
            issue(5'(g), 12'd8, 2'd0, 18'd0, 1'b0, 1'b0, 2'd0, 1'b0, span(g, 1), "R2");
        end
        issue(5'd16, 12'd8, 2'd0, 18'd0, 1'b0, 1'b0, 2'd0, 1'b1, span(56, 1), "R5");
        issue(5'd17, 12'd8, 2'd0, 18'd0, 1'b1, 1'b0, 2'd0, 1'b1, span(57, 1), "R5 sync");

        // R9: completion on cluster 0 lowers the count and frees slot 3.
        @(negedge clk);
        done_valid = 1'b1; done_gid = 5'd3;
        @(negedge clk);
        done_valid = 1'b0;
        issue(5'd18, 12'd8, 2'd0, 18'd0, 1'b0, 1'b0, 2'd0, 1'b0, span(3, 1), "R9 reuse");

        finish_run();
    end

endmodule